// File: doc/BRIEF.md
# DAC Ramp Power-Up Sequencer

This block sequences the power-up of a DAC output stage in two timed phases. A prescaler divides the timer clock into millisecond ticks. When the DAC enable input rises, the block first runs a fast-ramp phase and holds a fast-ramp enable output high for the whole of it. A complete-ramp phase then runs, and during this second phase the fast-ramp enable is low.

A single 32-bit configuration word holds three fields. Bits 15:0 give the number of timer-clock periods in one millisecond. Bits 23:16 give the fast-ramp length in milliseconds, and bits 31:24 give the complete-ramp length. The block copies the word into a shadow when the enable rises, so software can rewrite the word during a sequence without disturbing it. A sticky flag reports the end of each phase, and a one-cycle pulse marks the end of the whole sequence. Dropping the enable aborts the sequence and clears both flags.

Top module: `rdac_ramp_seq`

## Requirements
- R1: After reset the configuration word reads 0x3C0A1F40 (8000 clocks per millisecond, 10 ms fast, 60 ms complete), and fast_ramp_en, fast_done, comp_done and seq_done_pulse are all low.
- R2: A cycle with cfg_we high loads cfg_wdata into the configuration word, and cfg_rdata shows the new value from the next cycle on. Without cfg_we the word holds its value.
- R3: The clock edge that samples a rising dac_en starts the sequence. With D = bits 15:0 and a fast length N > 0 (bits 23:16), fast_ramp_en is high for exactly N*D cycles, starting at that edge.
- R4: fast_done sets at the same edge where fast_ramp_en falls. The complete-ramp phase starts at that edge, and comp_done sets M*D cycles later, where M is bits 31:24 and M > 0. fast_ramp_en and comp_done are never high together.
- R5: seq_done_pulse is high for exactly one cycle, in the cycle where comp_done first rises.
- R6: A fast length of zero never raises fast_ramp_en and sets fast_done one cycle after the start. A complete length of zero sets comp_done one cycle after the complete phase starts.
- R7: A divisor field of zero counts as a divisor of one.
- R8: The configuration is sampled at the starting edge. Writes to the word during a sequence do not change its timing.
- R9: When dac_en is sampled low, fast_ramp_en, fast_done and comp_done are all low from the next cycle on, whatever the phase.
- R10: clr_done bit 0 clears fast_done and clr_done bit 1 clears comp_done at the next edge. Each bit leaves the other flag unchanged.
- R11: While dac_en stays high after the sequence has finished, both flags stay set until they are cleared, and the sequence does not run again until dac_en falls and rises again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Write strobe for the configuration word |
| cfg_wdata | input | 32 | Configuration data to write |
| cfg_rdata | output | 32 | Current configuration word |
| dac_en | input | 1 | DAC enable; a rising edge starts the sequence and low aborts it |
| clr_done | input | 2 | Write-one-to-clear pulses: bit 0 fast flag, bit 1 complete flag |
| fast_ramp_en | output | 1 | Fast-ramp circuit enable, high during the fast phase |
| fast_done | output | 1 | Sticky flag: fast phase finished |
| comp_done | output | 1 | Sticky flag: complete phase finished |
| seq_done_pulse | output | 1 | One-cycle pulse when the complete phase finishes |

## Verification
Most faults in this block are off-by-one errors in the phase state machine or the prescaler. A wrong millisecond counter or a prescaler that does not restart moves the edges of fast_ramp_en and comp_done by whole cycles. The scoreboard therefore checks each output edge against the exact cycle computed from the configuration. A shadow that fails to hold its value shows up as changed timing in the first millisecond after a mid-sequence write. An abort path that leaves state behind shows up one cycle after dac_en falls, as a flag or an enable that is still set.

// File: rtl/rdac_pkg.sv
package rdac_pkg;
    parameter int DIV_W = 16;
    parameter int MS_W  = 8;
    parameter int CFG_W = DIV_W + 2 * MS_W;
    parameter logic [CFG_W-1:0] CFG_RESET = 32'h3C0A_1F40;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_FAST = 2'd1,
        PH_COMP = 2'd2,
        PH_HOLD = 2'd3
    } phase_e;

    typedef struct packed {
        logic [MS_W-1:0]  comp_ms;
        logic [MS_W-1:0]  fast_ms;
        logic [DIV_W-1:0] div;
    } ramp_cfg_t;
endpackage

// File: rtl/rdac_cfg_reg.sv
module rdac_cfg_reg
    import rdac_pkg::*;
#(
    parameter int                 W         = CFG_W,
    parameter logic [CFG_W-1:0]   RESET_VAL = CFG_RESET
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         we,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] word
);
    logic [W-1:0] word_d, word_q;

    always_comb begin
        word_d = word_q;
        if (we) word_d = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) word_q <= RESET_VAL[W-1:0];
        else        word_q <= word_d;
    end

    assign word = word_q;

    assert_cfg_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(word_q));
endmodule

// File: rtl/rdac_prescaler.sv
module rdac_prescaler
    import rdac_pkg::*;
#(
    parameter int W = DIV_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic         restart,
    input  logic [W-1:0] div,
    output logic         tick
);
    logic [W-1:0] pre_d, pre_q;
    logic         wrap;

    assign wrap = (pre_q == div - W'(1));

    always_comb begin
        pre_d = pre_q;
        if (restart || !run) pre_d = '0;
        else if (wrap)       pre_d = '0;
        else                 pre_d = pre_q + W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_d;
    end

    assign tick = run && wrap;

    assert_pre_in_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (run && div != '0) |-> (pre_q < div));
endmodule

// File: rtl/rdac_phase_fsm.sv
module rdac_phase_fsm
    import rdac_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      dac_en,
    input  logic [1:0] clr_done,
    input  ramp_cfg_t cfg,
    input  logic      tick,
    output logic      run,
    output logic      restart,
    output logic [DIV_W-1:0] div_eff,
    output logic      fast_en,
    output logic      fast_done,
    output logic      comp_done,
    output logic      done_pulse
);
    typedef struct packed {
        phase_e          ph;
        logic [MS_W-1:0] ms_left;
        ramp_cfg_t       shd;
        logic            en_prev;
        logic            fast_done;
        logic            comp_done;
        logic            pulse;
    } fsm_t;

    fsm_t st_d, st_q;
    logic rise;

    assign rise = dac_en && !st_q.en_prev;

    always_comb begin
        st_d         = st_q;
        st_d.en_prev = dac_en;
        st_d.pulse   = 1'b0;
        restart      = 1'b0;
        if (!dac_en) begin
            st_d.ph        = PH_IDLE;
            st_d.ms_left   = '0;
            st_d.fast_done = 1'b0;
            st_d.comp_done = 1'b0;
        end else begin
            if (clr_done[0]) st_d.fast_done = 1'b0;
            if (clr_done[1]) st_d.comp_done = 1'b0;
            unique case (st_q.ph)
                PH_IDLE: begin
                    if (rise) begin
                        st_d.shd     = cfg;
                        if (cfg.div == '0) st_d.shd.div = DIV_W'(1);
                        st_d.ph      = PH_FAST;
                        st_d.ms_left = cfg.fast_ms;
                        restart      = 1'b1;
                    end
                end
                PH_FAST: begin
                    if (st_q.ms_left == '0 || (tick && st_q.ms_left == MS_W'(1))) begin
                        st_d.fast_done = 1'b1;
                        st_d.ph        = PH_COMP;
                        st_d.ms_left   = st_q.shd.comp_ms;
                        restart        = 1'b1;
                    end else if (tick) begin
                        st_d.ms_left = st_q.ms_left - MS_W'(1);
                    end
                end
                PH_COMP: begin
                    if (st_q.ms_left == '0 || (tick && st_q.ms_left == MS_W'(1))) begin
                        st_d.comp_done = 1'b1;
                        st_d.pulse     = 1'b1;
                        st_d.ph        = PH_HOLD;
                        st_d.ms_left   = '0;
                    end else if (tick) begin
                        st_d.ms_left = st_q.ms_left - MS_W'(1);
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign run        = (st_q.ph == PH_FAST) || (st_q.ph == PH_COMP);
    assign div_eff    = st_q.shd.div;
    assign fast_en    = (st_q.ph == PH_FAST) && (st_q.ms_left != '0);
    assign fast_done  = st_q.fast_done;
    assign comp_done  = st_q.comp_done;
    assign done_pulse = st_q.pulse;

    assert_shadow_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ph != PH_IDLE && dac_en) |=> $stable(st_q.shd));
    assert_hold_no_restart_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ph == PH_HOLD && dac_en) |=> (st_q.ph == PH_HOLD));
endmodule

// File: rtl/rdac_ramp_seq.sv
module rdac_ramp_seq
    import rdac_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_we,
    input  logic [31:0] cfg_wdata,
    output logic [31:0] cfg_rdata,
    input  logic        dac_en,
    input  logic [1:0]  clr_done,
    output logic        fast_ramp_en,
    output logic        fast_done,
    output logic        comp_done,
    output logic        seq_done_pulse
);
    logic [CFG_W-1:0] cfg_word;
    ramp_cfg_t        cfg_s;
    logic             run, restart, tick;
    logic [DIV_W-1:0] div_eff;

    rdac_cfg_reg #(.W(CFG_W), .RESET_VAL(CFG_RESET)) i_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .wdata (cfg_wdata),
        .word  (cfg_word)
    );

    assign cfg_s     = cfg_word;
    assign cfg_rdata = cfg_word;

    rdac_prescaler #(.W(DIV_W)) i_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .restart (restart),
        .div     (div_eff),
        .tick    (tick)
    );

    rdac_phase_fsm i_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .dac_en     (dac_en),
        .clr_done   (clr_done),
        .cfg        (cfg_s),
        .tick       (tick),
        .run        (run),
        .restart    (restart),
        .div_eff    (div_eff),
        .fast_en    (fast_ramp_en),
        .fast_done  (fast_done),
        .comp_done  (comp_done),
        .done_pulse (seq_done_pulse)
    );

    assert_abort_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !dac_en |=> (!fast_ramp_en && !fast_done && !comp_done));
    assert_pulse_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        seq_done_pulse |=> !seq_done_pulse);
    assert_pulse_with_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
        seq_done_pulse |-> comp_done);
    assert_phase_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
        fast_ramp_en |-> !comp_done);
endmodule

// File: tb/test_rdac_ramp_seq.sv
module test_rdac_ramp_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        dac_en = 1'b0;
    logic [1:0]  clr_done = 2'b00;
    logic        fast_ramp_en, fast_done, comp_done, seq_done_pulse;

    always #4 clk = ~clk;

    rdac_ramp_seq i_rdac_ramp_seq (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .dac_en(dac_en), .clr_done(clr_done),
        .fast_ramp_en(fast_ramp_en), .fast_done(fast_done),
        .comp_done(comp_done), .seq_done_pulse(seq_done_pulse)
    );

    typedef struct { int kind; int cyc; string req; } exp_t;
    exp_t sb_q[$];

    int cyc = 0;
    int n_chk = 0;
    int n_fail = 0;
    bit mon_on = 1'b1;
    logic p_fen = 0, p_fd = 0, p_cd = 0, p_pl = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(bit ok, string req, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    // monitor: compare each observed output edge with the scoreboard head
    task automatic observe(int kind);
        if (sb_q.size() == 0) begin
            check(0, "R3 unexpected event", kind, -1);
        end else begin
            exp_t e = sb_q.pop_front();
            check(e.kind == kind, e.req, kind, e.kind);
            check(e.cyc == cyc, e.req, cyc, e.cyc);
        end
    endtask

    always @(negedge clk) begin
        if (mon_on && rst_n) begin
            if (fast_ramp_en && !p_fen)   observe(0);
            if (!fast_ramp_en && p_fen)   observe(1);
            if (fast_done && !p_fd)       observe(2);
            if (comp_done && !p_cd)       observe(3);
            if (seq_done_pulse && !p_pl)  observe(4);
        end
        p_fen = fast_ramp_en; p_fd = fast_done; p_cd = comp_done; p_pl = seq_done_pulse;
    end

    always @(negedge clk) begin
        if (cyc > 150000) begin
            check(0, "watchdog", cyc, 150000);
            finish_run();
        end
    end

    task automatic push(int kind, int c, string req);
        exp_t e;
        e.kind = kind; e.cyc = c; e.req = req;
        sb_q.push_back(e);
    endtask

    task automatic write_cfg(int div, int n, int m);
        @(negedge clk);
        cfg_we = 1'b1;
        cfg_wdata = {m[7:0], n[7:0], div[15:0]};
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // driver: start a sequence and push the expected events
    task automatic start_seq(int div, int n, int m, string req);
        int d, s, cs, cd;
        d = (div == 0) ? 1 : div;
        @(negedge clk);
        dac_en = 1'b1;
        s = cyc + 1;
        if (n > 0) begin
            push(0, s, {req, " fast_en rise R3"});
            push(1, s + n * d, {req, " fast_en fall R3"});
            push(2, s + n * d, {req, " fast_done R4"});
            cs = s + n * d;
        end else begin
            push(2, s + 1, {req, " fast_done zero R6"});
            cs = s + 1;
        end
        cd = (m > 0) ? cs + m * d : cs + 1;
        push(3, cd, {req, " comp_done R4"});
        push(4, cd, {req, " pulse R5"});
    endtask

    task automatic drain(string req);
        int k = 0;
        while (sb_q.size() != 0 && k < 2000) begin
            @(negedge clk);
            k++;
        end
        check(sb_q.size() == 0, req, sb_q.size(), 0);
        sb_q.delete();
    endtask

    task automatic stop_seq();
        @(negedge clk);
        dac_en = 1'b0;
        @(negedge clk);
        check(!fast_ramp_en && !fast_done && !comp_done, "R9 flags after drop",
              {fast_ramp_en, fast_done, comp_done}, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(cfg_rdata == 32'h3C0A_1F40, "R1 reset cfg", cfg_rdata, 32'h3C0A_1F40);
        check({fast_ramp_en, fast_done, comp_done, seq_done_pulse} == 0, "R1 reset outputs",
              {fast_ramp_en, fast_done, comp_done, seq_done_pulse}, 0);

        write_cfg(3, 2, 3);
        check(cfg_rdata == {8'd3, 8'd2, 16'd3}, "R2 cfg write", cfg_rdata, {8'd3, 8'd2, 16'd3});
        repeat (2) @(negedge clk);
        check(cfg_rdata == {8'd3, 8'd2, 16'd3}, "R2 cfg hold", cfg_rdata, {8'd3, 8'd2, 16'd3});

        // basic sequence
        start_seq(3, 2, 3, "basic");
        drain("R3 basic drained");
        repeat (5) @(negedge clk);
        check(fast_done && comp_done && !fast_ramp_en, "R11 sticky flags",
              {fast_ramp_en, fast_done, comp_done}, 3);
        stop_seq();

        // configuration changed mid-sequence is ignored
        write_cfg(2, 1, 2);
        start_seq(2, 1, 2, "R8 shadow");
        @(negedge clk);
        cfg_we = 1'b1; cfg_wdata = {8'd4, 8'd4, 16'd5};
        @(negedge clk);
        cfg_we = 1'b0;
        drain("R8 shadow drained");
        stop_seq();

        // zero-length phases
        write_cfg(2, 0, 2);
        start_seq(2, 0, 2, "R6 zero fast");
        drain("R6 zero fast drained");
        stop_seq();
        write_cfg(2, 3, 0);
        start_seq(2, 3, 0, "R6 zero comp");
        drain("R6 zero comp drained");
        stop_seq();

        // divisor zero counts as one
        write_cfg(0, 3, 2);
        start_seq(0, 3, 2, "R7 div zero");
        drain("R7 div zero drained");
        stop_seq();

        // abort in fast phase
        write_cfg(4, 5, 1);
        mon_on = 1'b0;
        @(negedge clk);
        dac_en = 1'b1;
        repeat (6) @(negedge clk);
        check(fast_ramp_en && !fast_done, "R9 fast active before abort",
              {fast_ramp_en, fast_done}, 2);
        stop_seq();
        repeat (30) @(negedge clk);
        check(!fast_ramp_en && !fast_done && !comp_done, "R9 stays idle after abort",
              {fast_ramp_en, fast_done, comp_done}, 0);
        mon_on = 1'b1;

        // sequence after abort, then flag clears
        write_cfg(2, 2, 2);
        start_seq(2, 2, 2, "restart");
        drain("R3 restart drained");
        @(negedge clk);
        clr_done = 2'b01;
        @(negedge clk);
        clr_done = 2'b00;
        check(!fast_done && comp_done, "R10 clear fast flag", {fast_done, comp_done}, 1);
        clr_done = 2'b10;
        @(negedge clk);
        clr_done = 2'b00;
        check(!fast_done && !comp_done, "R10 clear comp flag", {fast_done, comp_done}, 0);
        repeat (20) @(negedge clk);
        check(!fast_ramp_en && !fast_done && !comp_done && sb_q.size() == 0,
              "R11 no rerun while enable held", {fast_ramp_en, fast_done, comp_done}, 0);
        stop_seq();

        finish_run();
    end
endmodule